// File: doc/BRIEF.md
# Upper BIOS Area Shadow Decoder

This block sorts every CPU access that lands in the top 128 KB of the first megabyte (0x0E0000 to 0x0FFFFF), or in its mirror just below 16 MB (0x FE0000 to 0xFFFFFF), into one of four classes: boot ROM chip select, external bus, internal RAM read, or a blocked write. Accesses outside both windows get no class. The class is registered, so the outputs for an access show up one clock after the access is presented.

The block has two 64 KB halves: E (0xE0000 to 0xEFFFF) and F (0xF0000 to 0xFFFFF). A two-bit shadow mode selects which halves are served from RAM. A low-window address and its mirror address always resolve to the same RAM byte. The mode only counts while a separate shadow enable is set. It also needs the installed memory to reach past the start of the area it shadows.

In a shadowed half, reads go to RAM and writes are dropped. Outside a shadowed half, default decoding applies. The mirror window always selects the ROM. The low window selects the ROM unless a ROM-redirect control sends it to the external bus. On early silicon the low window selects the ROM regardless of that control.

Top module: `bios_shadow_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, all class outputs and `ram_addr` are zero one cycle later, whatever the access inputs are.
- R2: Any cycle after an edge where `acc_valid` was low gives all-zero outputs. An access whose address falls outside both 128 KB windows also gives all-zero outputs.
- R3: The outputs for an access appear on the first clock edge after it is presented. At most one of `rom_cs`, `ram_sel`, `ext_sel` and `write_block` is high.
- R4: With `shadow_en` low, `shadow_mode` has no effect. The default decode is used and neither `ram_sel` nor `write_block` is ever raised.
- R5: In default decode, every access to 0xFE0000 to 0xFFFFFF raises `rom_cs`. This holds for both reads and writes.
- R6: In default decode, an access to 0x0E0000 to 0x0FFFFF raises `ext_sel` only when `rom_to_ext` is 1 and `early_rev` is 0. In every other case it raises `rom_cs`.
- R7: `shadow_mode` = 2'b11 shadows both halves and both mirrors. A read raises `ram_sel` with `ram_addr` equal to address bits 19:0, so mirror address 0xFFxxxx maps to RAM 0xFxxxx.
- R8: `shadow_mode` = 2'b10 shadows only the F half and its mirror 0xFF0000 to 0xFFFFFF. The E half and its mirror keep the default decode.
- R9: `shadow_mode` = 2'b01 shadows only the E half and its mirror 0xFE0000 to 0xFEFFFF. The F half and its mirror keep the default decode.
- R10: A write to a shadowed half raises only `write_block`. `ram_sel` stays low, so the write has no effect on memory.
- R11: Modes 2'b11 and 2'b01 need `mem_top` > 0xE0000, and mode 2'b10 needs `mem_top` > 0xF0000. Otherwise no shadowing occurs. In mode 2'b11, meeting the 0xE0000 limit shadows both halves.
- R12: `ram_addr` is zero whenever `ram_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W (24) | Byte address of the access |
| acc_write | input | 1 | 1 for write, 0 for read |
| shadow_en | input | 1 | Qualifies `shadow_mode` |
| shadow_mode | input | 2 | Bit 1 shadows the F half, bit 0 shadows the E half |
| rom_to_ext | input | 1 | Sends the non-shadowed low window to the external bus |
| early_rev | input | 1 | Early silicon: the low window always selects ROM |
| mem_top | input | ADDR_W+1 (25) | First address past installed memory |
| rom_cs | output | 1 | Boot ROM chip select |
| ram_sel | output | 1 | Read served from internal RAM |
| ext_sel | output | 1 | Access goes to the external bus |
| write_block | output | 1 | Write is completed and discarded |
| ram_addr | output | LOW_AW (20) | RAM byte address while `ram_sel` is high |

## Verification
Directed cases walk each shadow mode through both halves and both mirrors, so a wrong mode-to-half assignment shows up as a ROM select where a RAM read was expected. The enable, the ROM-redirect control and the early-silicon input are each toggled while the address is held fixed. That separates their effect on the default decode from their effect on shadowing. The memory limit is placed exactly at and one byte past 0xE0000 and 0xF0000, which exposes an off-by-one compare or a limit paired with the wrong mode. Seeded random accesses are biased toward window edges and mixed reads and writes, and they compare all outputs against an independent model.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    // Which 128 KB window an address falls in
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LOW   = 2'd1,
        WIN_ALIAS = 2'd2
    } win_e;

    // Registered decode class
    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_ROM   = 3'd1,
        CLS_EXT   = 3'd2,
        CLS_RAM   = 3'd3,
        CLS_BLOCK = 3'd4
    } cls_e;

    typedef struct packed {
        win_e win;
        logic half;   // 0: lower 64 KB half, 1: upper half
    } match_t;

    localparam int NUM_HALF = 2;

    // Start of the region a given mode protects, as an offset below the 1 MB top
    function automatic longint unsigned shadow_floor(input logic [1:0] mode,
                                                     input int low_aw,
                                                     input int seg_w);
        longint unsigned top;
        top = longint'(1) << low_aw;
        if (mode[0])
            return top - (longint'(1) << (seg_w + 1));
        return top - (longint'(1) << seg_w);
    endfunction

endpackage

// File: rtl/bsd_window.sv
module bsd_window
    import bsd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_AW = 20,
    parameter int SEG_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output match_t            hit
);
    localparam int WIN_LSB = SEG_W + 1;

    logic above_low;
    logic low_top;
    logic alias_top;

    always_comb begin
        above_low = |addr[ADDR_W-1:LOW_AW];
        low_top   = &addr[LOW_AW-1:WIN_LSB];
        alias_top = &addr[ADDR_W-1:WIN_LSB];
        hit.half  = addr[SEG_W];
        if (alias_top)
            hit.win = WIN_ALIAS;
        else if (!above_low && low_top)
            hit.win = WIN_LOW;
        else
            hit.win = WIN_NONE;
    end
endmodule

// File: rtl/bsd_policy.sv
module bsd_policy
    import bsd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_AW = 20,
    parameter int SEG_W  = 16
) (
    input  logic                shadow_en,
    input  logic [1:0]          shadow_mode,
    input  logic [ADDR_W:0]     mem_top,
    output logic [NUM_HALF-1:0] half_shadow
);
    localparam int MT_W = ADDR_W + 1;
    localparam logic [MT_W-1:0] FLOOR_BOTH  = MT_W'(shadow_floor(2'b01, LOW_AW, SEG_W));
    localparam logic [MT_W-1:0] FLOOR_UPPER = MT_W'(shadow_floor(2'b10, LOW_AW, SEG_W));

    logic [1:0]      eff_mode;
    logic [MT_W-1:0] floor_addr;
    logic            active;

    always_comb begin
        eff_mode   = shadow_en ? shadow_mode : 2'b00;
        floor_addr = eff_mode[0] ? FLOOR_BOTH : FLOOR_UPPER;
        active     = (eff_mode != 2'b00) && (mem_top > floor_addr);
    end

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        assign half_shadow[h] = active & eff_mode[h];
    end
endmodule

// File: rtl/bsd_classify.sv
module bsd_classify
    import bsd_pkg::*;
(
    input  logic                acc_valid,
    input  logic                acc_write,
    input  match_t              hit,
    input  logic [NUM_HALF-1:0] half_shadow,
    input  logic                rom_to_ext,
    input  logic                early_rev,
    output cls_e                cls
);
    logic shadowed;

    always_comb begin
        shadowed = half_shadow[hit.half];
        cls      = CLS_NONE;
        if (acc_valid && hit.win != WIN_NONE) begin
            if (shadowed)
                cls = acc_write ? CLS_BLOCK : CLS_RAM;
            else if (hit.win == WIN_ALIAS)
                cls = CLS_ROM;
            else if (rom_to_ext && !early_rev)
                cls = CLS_EXT;
            else
                cls = CLS_ROM;
        end
    end
endmodule

// File: rtl/bios_shadow_decoder.sv
module bios_shadow_decoder
    import bsd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_AW = 20,
    parameter int SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              shadow_en,
    input  logic [1:0]        shadow_mode,
    input  logic              rom_to_ext,
    input  logic              early_rev,
    input  logic [ADDR_W:0]   mem_top,
    output logic              rom_cs,
    output logic              ram_sel,
    output logic              ext_sel,
    output logic              write_block,
    output logic [LOW_AW-1:0] ram_addr
);
    match_t              hit;
    logic [NUM_HALF-1:0] half_shadow;
    cls_e                cls_d;
    cls_e                cls_q;
    logic [LOW_AW-1:0]   addr_q;

    bsd_window #(.ADDR_W(ADDR_W), .LOW_AW(LOW_AW), .SEG_W(SEG_W)) u_window (
        .addr (acc_addr),
        .hit  (hit)
    );

    bsd_policy #(.ADDR_W(ADDR_W), .LOW_AW(LOW_AW), .SEG_W(SEG_W)) u_policy (
        .shadow_en   (shadow_en),
        .shadow_mode (shadow_mode),
        .mem_top     (mem_top),
        .half_shadow (half_shadow)
    );

    bsd_classify u_classify (
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .hit         (hit),
        .half_shadow (half_shadow),
        .rom_to_ext  (rom_to_ext),
        .early_rev   (early_rev),
        .cls         (cls_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q  <= CLS_NONE;
            addr_q <= '0;
        end else begin
            cls_q  <= cls_d;
            addr_q <= (cls_d == CLS_RAM) ? acc_addr[LOW_AW-1:0] : '0;
        end
    end

    always_comb begin
        rom_cs      = (cls_q == CLS_ROM);
        ram_sel     = (cls_q == CLS_RAM);
        ext_sel     = (cls_q == CLS_EXT);
        write_block = (cls_q == CLS_BLOCK);
        ram_addr    = addr_q;
    end
endmodule

// File: rtl/bios_shadow_decoder_chk.sv
module bios_shadow_decoder_chk #(
    parameter int ADDR_W = 24,
    parameter int LOW_AW = 20,
    parameter int SEG_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              shadow_en,
    input logic              rom_cs,
    input logic              ram_sel,
    input logic              ext_sel,
    input logic              write_block,
    input logic [LOW_AW-1:0] ram_addr
);
    // R3
    class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_cs, ram_sel, ext_sel, write_block}));

    // R12
    addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_sel |-> (ram_addr == '0));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !(rom_cs | ram_sel | ext_sel | write_block));

    // R10
    write_no_ram_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> !ram_sel);

    // R4
    shadow_off_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !shadow_en) |=> !(ram_sel | write_block));

    // R5
    alias_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !shadow_en && (&acc_addr[ADDR_W-1:SEG_W+1])) |=> rom_cs);
endmodule

bind bios_shadow_decoder bios_shadow_decoder_chk #(
    .ADDR_W(ADDR_W), .LOW_AW(LOW_AW), .SEG_W(SEG_W)
) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .shadow_en(shadow_en), .rom_cs(rom_cs),
    .ram_sel(ram_sel), .ext_sel(ext_sel), .write_block(write_block),
    .ram_addr(ram_addr)
);

// File: tb/bios_shadow_decoder_tb_top.sv
module bios_shadow_decoder_tb_top;
    localparam int ADDR_W = 24;
    localparam int LOW_AW = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_write = 1'b0;
    logic              shadow_en = 1'b0;
    logic [1:0]        shadow_mode = 2'b00;
    logic              rom_to_ext = 1'b0;
    logic              early_rev = 1'b0;
    logic [ADDR_W:0]   mem_top = 25'h100000;
    logic              rom_cs, ram_sel, ext_sel, write_block;
    logic [LOW_AW-1:0] ram_addr;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    bios_shadow_decoder dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .shadow_en(shadow_en), .shadow_mode(shadow_mode),
        .rom_to_ext(rom_to_ext), .early_rev(early_rev), .mem_top(mem_top),
        .rom_cs(rom_cs), .ram_sel(ram_sel), .ext_sel(ext_sel),
        .write_block(write_block), .ram_addr(ram_addr)
    );

    // Expected {rom, ram, ext, block, ram_addr} from the requirements
    function automatic logic [23:0] model(input logic v, input logic [23:0] a,
                                          input logic w, input logic en,
                                          input logic [1:0] md, input logic ext,
                                          input logic early, input logic [24:0] top);
        logic       in_low, in_alias, act, sh;
        logic [1:0] m;
        logic [24:0] thr;
        if (!v) return 24'h0;
        in_low   = (a[23:20] == 4'h0) && (a[19:17] == 3'b111);
        in_alias = (a[23:17] == 7'h7F);
        if (!in_low && !in_alias) return 24'h0;
        m   = en ? md : 2'b00;
        thr = m[0] ? 25'h0E0000 : 25'h0F0000;
        act = (m != 2'b00) && (top > thr);
        sh  = act && m[a[16]];
        if (sh) return w ? {4'b0001, 20'h0} : {4'b0100, a[19:0]};
        if (in_alias) return {4'b1000, 20'h0};
        if (ext && !early) return {4'b0010, 20'h0};
        return {4'b1000, 20'h0};
    endfunction

    task automatic compare(input string tag);
        logic [23:0] exp_v, act_v;
        exp_v = model(acc_valid, acc_addr, acc_write, shadow_en, shadow_mode,
                      rom_to_ext, early_rev, mem_top);
        if (rst) exp_v = 24'h0;
        act_v = {rom_cs, ram_sel, ext_sel, write_block, ram_addr};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s addr=%h wr=%0b actual=%h expected=%h",
                     tag, acc_addr, acc_write, act_v, exp_v);
        end
    endtask

    task automatic cfg(input logic en, input logic [1:0] md, input logic ext,
                       input logic early, input logic [24:0] top);
        shadow_en = en; shadow_mode = md; rom_to_ext = ext;
        early_rev = early; mem_top = top;
    endtask

    task automatic access(input logic [23:0] a, input logic w, input string tag);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        acc_valid = 1'b0;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        void'($urandom(32'd4711));
        // R1: reset with an access presented
        cfg(1'b1, 2'b11, 1'b0, 1'b0, 25'h100000);
        acc_valid = 1'b1; acc_addr = 24'h0E0000;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst = 1'b0;
        idle("R2 idle after reset");

        // R2: outside both windows
        cfg(1'b0, 2'b00, 1'b0, 1'b0, 25'h100000);
        access(24'h0DFFFF, 1'b0, "R2 below low window");
        access(24'h100000, 1'b0, "R2 above 1MB");
        access(24'hFDFFFF, 1'b1, "R2 below alias");
        access(24'h1E0000, 1'b0, "R2 low bits match, upper set");

        // R5 / R6 default decode
        access(24'hFE0000, 1'b0, "R5 alias start");
        access(24'hFFFFFF, 1'b1, "R5 alias end write");
        access(24'h0E0000, 1'b0, "R6 low rom");
        cfg(1'b0, 2'b00, 1'b1, 1'b0, 25'h100000);
        access(24'h0FFFFF, 1'b0, "R6 low ext");
        access(24'hFE8000, 1'b0, "R5 alias ignores redirect");
        cfg(1'b0, 2'b00, 1'b1, 1'b1, 25'h100000);
        access(24'h0F1234, 1'b1, "R6 early silicon rom");

        // R4: mode ignored without enable
        cfg(1'b0, 2'b11, 1'b0, 1'b0, 25'h100000);
        access(24'h0E1234, 1'b0, "R4 disabled mode low");
        access(24'hFF0000, 1'b1, "R4 disabled mode alias");

        // R7 both halves
        cfg(1'b1, 2'b11, 1'b1, 1'b0, 25'h100000);
        access(24'h0E1234, 1'b0, "R7 E half");
        access(24'hFF5678, 1'b0, "R7 alias F half");
        access(24'hFE0001, 1'b0, "R7 alias E half");
        // R10
        access(24'h0E0000, 1'b1, "R10 blocked write low");
        access(24'hFFFFFE, 1'b1, "R10 blocked write alias");
        // R3: one cycle then back to idle
        access(24'h0F00AA, 1'b0, "R3 latency");
        idle("R3 idle follows");

        // R8 upper half only
        cfg(1'b1, 2'b10, 1'b0, 1'b0, 25'h100000);
        access(24'h0F0000, 1'b0, "R8 F half");
        access(24'h0EFFFF, 1'b0, "R8 E half default");
        access(24'hFE0000, 1'b0, "R8 E alias default");
        access(24'hFF0000, 1'b0, "R8 F alias");

        // R9 lower half only
        cfg(1'b1, 2'b01, 1'b1, 1'b0, 25'h100000);
        access(24'h0E0000, 1'b0, "R9 E half");
        access(24'h0F0000, 1'b0, "R9 F half default ext");
        access(24'hFEFFFF, 1'b0, "R9 E alias");
        access(24'hFF0000, 1'b1, "R9 F alias default");

        // R11 memory limits
        cfg(1'b1, 2'b10, 1'b0, 1'b0, 25'h0F0000);
        access(24'h0F0000, 1'b0, "R11 upper limit equal");
        cfg(1'b1, 2'b10, 1'b0, 1'b0, 25'h0F0001);
        access(24'h0F0000, 1'b0, "R11 upper limit past");
        cfg(1'b1, 2'b01, 1'b0, 1'b0, 25'h0E0000);
        access(24'h0E0000, 1'b0, "R11 lower limit equal");
        cfg(1'b1, 2'b11, 1'b0, 1'b0, 25'h0E8000);
        access(24'h0F8000, 1'b0, "R11 both halves low limit");
        // R12
        access(24'h0F8000, 1'b1, "R12 address quiet on block");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            if (i % 8 == 0)
                cfg(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                    (($urandom % 4) == 0) ? 25'($urandom) : 25'(32'h0E0000 + ($urandom % 3) * 32'h10000 - 1 + ($urandom % 3)));
            case ($urandom % 4)
                0: a = 24'h0E0000 | 24'($urandom % 32'h20000);
                1: a = 24'hFE0000 | 24'($urandom % 32'h20000);
                2: a = 24'($urandom);
                default: a = 24'(32'h0E0000 + $urandom % 3 - 1) ^ (($urandom % 2) ? 24'hF00000 : 24'h0);
            endcase
            acc_valid = ($urandom % 6) != 0;
            acc_addr = a;
            acc_write = 1'($urandom);
            @(negedge clk);
            compare("R3 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule